// File: doc/BRIEF.md
# Packed Halfword Averaging Unit

This block averages two packed operands lane by lane. Each operand holds signed lanes of `LANE_W` bits. Each lane adds its two inputs with one extra bit of precision and halves the sum. When the sum is odd, the halved value lies exactly between two integers, and a programmable rule decides which of the two is returned. The lane results are packed back into a word of the same width as the operands. The result appears one clock after the operands are accepted.

The rounding rule is held in a small control register, loaded through a one-cycle write port. A select bit chooses between two schemes:

- a 2-bit field naming one of four directed modes;
- a single legacy bit that chooses round-up or floor.

A build parameter removes the rounding logic entirely, and every odd sum then floors.

Top module: `halfword_avg`

## Requirements
- R1: Lane i of `op_a` and `op_b` (bits [i*LANE_W +: LANE_W], two's complement) produces result bits [i*LANE_W +: LANE_W], so with the default build the low halves give result[15:0] and the high halves give result[31:16].
- R2: The lane sum is formed with LANE_W+1 bits, so it never overflows: 0x7FFF with 0x7FFF gives 0x7FFF, and 0x8000 with 0x8000 gives 0x8000.
- R3: When a lane sum is even, the lane result is exactly half the sum under every configuration.
- R4: An operand pair accepted with `in_valid` high yields `out_valid` high with its result on the next cycle; with `in_valid` low, `out_valid` is low on the next cycle and `result` keeps its value.
- R5: After reset, `out_valid` and `result` are zero and the control register is zero, so odd sums floor.
- R6: Control layout: `cfg_wdata[3]` = mode select, `cfg_wdata[2:1]` = directed mode, `cfg_wdata[0]` = legacy round-up. With select=1 and mode 0 (nearest), an odd sum gives floor(sum/2)+1.
- R7: With select=1 and mode 1 (toward zero), an odd sum gives floor(sum/2)+1 only when floor(sum/2) is negative; otherwise it gives floor(sum/2).
- R8: With select=1 and mode 2 (toward +inf), an odd sum gives floor(sum/2)+1.
- R9: With select=1 and mode 3 (toward -inf), an odd sum gives floor(sum/2).
- R10: With select=0, an odd sum gives floor(sum/2)+1 when the legacy bit is 1 and floor(sum/2) when it is 0; the mode field is ignored.
- R11: A control write takes effect for operands accepted after the write cycle; operands accepted in the write cycle itself use the previous setting.
- R12: With `ROUND_EN`=0, every odd sum gives floor(sum/2) whatever the control register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control value: [3] select, [2:1] directed mode, [0] legacy round-up |
| in_valid | input | 1 | Operand pair valid |
| op_a | input | LANE_W*LANES | First packed operand |
| op_b | input | LANE_W*LANES | Second packed operand |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | LANE_W*LANES | Packed lane averages |

## Verification
The bench builds two copies of the unit with two 16-bit lanes. The first uses `ROUND_EN`=1, which brings every directed mode, both legacy settings and the timing of control writes within reach. The second uses `ROUND_EN`=0, so each stimulus also shows that this build always floors, even when the control register selects an upward mode. Both copies see the same operands, which include:

- lane extremes;
- mixed-sign sums;
- odd sums whose floor is -1 or 0, where the toward-zero rule decides.

// File: rtl/halfword_avg.sv
module halfword_avg #(
  parameter int LANE_W   = 16,
  parameter int LANES    = 2,
  parameter bit ROUND_EN = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [3:0]                cfg_wdata,
  input  logic                      in_valid,
  input  logic [LANE_W*LANES-1:0]   op_a,
  input  logic [LANE_W*LANES-1:0]   op_b,
  output logic                      out_valid,
  output logic [LANE_W*LANES-1:0]   result
);
  localparam int W = LANE_W * LANES;

  logic [3:0]   cfg_q;
  logic [W-1:0] avg_next;

  wire       sel_dir = cfg_q[3];
  wire [1:0] dir     = cfg_q[2:1];
  wire       up_bit  = cfg_q[0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [LANE_W-1:0] a = op_a[i*LANE_W +: LANE_W];
    wire [LANE_W-1:0] b = op_b[i*LANE_W +: LANE_W];
    wire [LANE_W:0]   sum = {a[LANE_W-1], a} + {b[LANE_W-1], b};
    wire [LANE_W-1:0] fl  = sum[LANE_W:1];
    logic             bump;
    always_comb begin
      if (!ROUND_EN || !sum[0])
        bump = 1'b0;
      else if (sel_dir)
        case (dir)
          2'd0, 2'd2: bump = 1'b1;
          2'd1:       bump = fl[LANE_W-1];
          default:    bump = 1'b0;
        endcase
      else
        bump = up_bit;
    end
    assign avg_next[i*LANE_W +: LANE_W] = fl + {{(LANE_W-1){1'b0}}, bump};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      out_valid <= in_valid;
      if (in_valid) result <= avg_next;
    end
  end
endmodule

// File: rtl/halfword_avg_chk.sv
module halfword_avg_chk #(
  parameter int LANE_W   = 16,
  parameter int LANES    = 2,
  parameter bit ROUND_EN = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [3:0]              cfg_q,
  input logic [LANE_W*LANES-1:0] op_a,
  input logic [LANE_W*LANES-1:0] op_b,
  input logic                    out_valid,
  input logic [LANE_W*LANES-1:0] result
);
  wire [LANE_W:0] s0 = {op_a[LANE_W-1], op_a[LANE_W-1:0]} + {op_b[LANE_W-1], op_b[LANE_W-1:0]};

  logic [LANE_W:0] s0_q;
  logic            dn_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s0_q <= '0;
      dn_q <= 1'b0;
    end else begin
      s0_q <= s0;
      dn_q <= (cfg_q == 4'b1110);
    end

  wire [LANE_W-1:0] delta0 = result[LANE_W-1:0] - s0_q[LANE_W:1];

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  // R3
  even_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !s0[0]) |=> (delta0 == '0));

  // R1
  lane0_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (delta0 <= 1));

  // R9
  down_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_q == 4'b1110) |=> (dn_q && delta0 == '0));

  if (!ROUND_EN) begin : g_floor
    // R12
    floor_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (delta0 == '0));
  end
endmodule

bind halfword_avg halfword_avg_chk #(.LANE_W(LANE_W), .LANES(LANES), .ROUND_EN(ROUND_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_q(cfg_q),
  .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
);

// File: tb/test_halfword_avg.sv
module test_halfword_avg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        ov_r, ov_f;
  logic [31:0] res_r, res_f;

  int errors = 0;
  int checks = 0;
  logic [3:0] cfg_model = '0;
  bit done = 0;

  typedef struct { logic [31:0] er; logic [31:0] ef; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  halfword_avg i_halfword_avg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .op_a(op_a), .op_b(op_b), .out_valid(ov_r), .result(res_r));

  halfword_avg #(.ROUND_EN(1'b0)) i_halfword_avg_floor (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .op_a(op_a), .op_b(op_b), .out_valid(ov_f), .result(res_f));

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0] c, input bit ren);
    logic [31:0] r;
    for (int i = 0; i < 2; i++) begin
      int s;
      int f;
      bit up;
      s  = int'($signed(a[i*16 +: 16])) + int'($signed(b[i*16 +: 16]));
      f  = s >>> 1;
      up = 0;
      if (ren && (s & 1)) begin
        if (c[3]) up = (c[2:1] == 2'd0) || (c[2:1] == 2'd2) || (c[2:1] == 2'd1 && f < 0);
        else      up = c[0];
      end
      r[i*16 +: 16] = 16'(f + int'(up));
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    it.er = model(a, b, cfg_model, 1'b1);
    it.ef = model(a, b, cfg_model, 1'b0);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      cfg_we = 1'b0;
    end
  endtask

  task automatic write_cfg(input logic [3:0] v);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_model = v;
  endtask

  logic [31:0] last_r = '0;
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (ov_r) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4: actual=out_valid 1 expected=out_valid 0");
        end else begin
          item_t it;
          it = sb.pop_front();
          check(it.tag, res_r, it.er);
          check({it.tag, " R12"}, res_f, it.ef);
          check("R4 floor build valid", {31'd0, ov_f}, 32'd1);
        end
        last_r = res_r;
      end else begin
        if (sb.size() != 0) begin
          checks++; errors++;
          $display("FAIL R4: actual=out_valid 0 expected=out_valid 1");
          void'(sb.pop_front());
        end
        if (res_r !== last_r) begin
          checks++; errors++;
          $display("FAIL R4: actual=%h expected=%h (hold)", res_r, last_r);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 out_valid", {31'd0, ov_r}, 32'd0);
    check("R5 result", res_r, 32'd0);

    // R5 reset config floors; R1 lane mapping
    send(32'h0003_0001, 32'h0000_0000, "R5 R1 floor after reset");
    send(32'h0010_FFFF, 32'h0002_FFFC, "R1 lanes independent");
    // R2 full-precision sum
    send(32'h7FFF_8000, 32'h7FFF_8000, "R2 extremes");
    send(32'h7FFF_8000, 32'h7FFE_8001, "R2 odd extremes");
    idle(2);
    // R3 even sums
    write_cfg(4'b1000);
    send(32'h0004_FFFA, 32'h0002_FFFC, "R3 even nearest");
    // R6 nearest
    send(32'h0003_FFFD, 32'h0000_0000, "R6 nearest odd");
    idle(1);
    // R7 toward zero
    write_cfg(4'b1010);
    send(32'h0003_FFFD, 32'h0000_0000, "R7 zero pos/neg");
    send(32'h0001_FFFF, 32'h0000_0000, "R7 zero near 0");
    send(32'h0006_FFF0, 32'h0002_FFF2, "R3 even zero");
    // R8 toward +inf
    write_cfg(4'b1100);
    send(32'h0003_FFFD, 32'h0000_0000, "R8 +inf");
    send(32'h7FFF_8000, 32'h7FFE_8001, "R8 +inf extremes");
    // R9 toward -inf
    write_cfg(4'b1110);
    send(32'h0003_FFFD, 32'h0000_0000, "R9 -inf");
    // R10 legacy bit, mode field ignored
    write_cfg(4'b0111);
    send(32'h0003_FFFD, 32'h0000_0000, "R10 legacy up");
    write_cfg(4'b0110);
    send(32'h0003_FFFD, 32'h0000_0000, "R10 legacy floor");
    idle(1);
    // R11 write in same cycle as operands uses old setting
    @(negedge clk);
    begin
      item_t it;
      in_valid = 1'b1; op_a = 32'h0005_FFFB; op_b = 32'h0000_0000;
      cfg_we = 1'b1; cfg_wdata = 4'b0001;
      it.er = model(op_a, op_b, cfg_model, 1'b1);
      it.ef = model(op_a, op_b, cfg_model, 1'b0);
      it.tag = "R11 same-cycle old cfg";
      sb.push_back(it);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_model = 4'b0001;
    in_valid = 1'b0;
    send(32'h0005_FFFB, 32'h0000_0000, "R11 new cfg next");
    idle(3);
    done = 1;
    check("R4 queue drained", 32'(sb.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule